// File: doc/BRIEF.md
# Touch Packet Decoder with Window Clip and Rescale

The block turns a data-ready pulse from a capacitive touch sensor into one decoded position record. A rising edge on `drdy_i` starts a fetch: the block reads the sensor's packet bytes one at a time through a simple register-access request/response port. It then writes zero to the sensor's status register to acknowledge the sample, decodes the bytes and emits the result with a single-cycle `out_valid_o` strobe.

Two packet formats are handled. In relative mode the record is a signed motion delta on X and Y plus an optional tap button. In absolute mode it carries 12-bit X and Y coordinates and a 6-bit pressure value. Absolute coordinates can optionally be clamped to a per-axis window. When clamping is enabled they can also be remapped onto a target resolution by a pair of multi-cycle dividers that run side by side. A sample whose X, Y and pressure are all zero means the finger has lifted; it is passed through untouched.

A data-ready edge that arrives while a fetch is in progress is remembered and serviced once the current record is out. Several such edges collapse into one further fetch.

Top module: `touch_packet_decoder`

## Requirements
- R1: After reset, `out_valid_o` and `req_valid_o` are low, and no request is issued until a rising edge is seen on `drdy_i`.
- R2: Each 0-to-1 transition of `drdy_i` starts exactly one fetch. Holding `drdy_i` high starts no further fetch.
- R3: A relative-mode fetch issues exactly 3 reads, to addresses 0x12, 0x13 and 0x14 in that order. An absolute-mode fetch issues exactly 4 reads, to 0x14, 0x15, 0x16 and 0x17. A request holds its address and kind until `req_ready_i` accepts it. Its data comes back on the next `rsp_valid_i`.
- R4: Relative decode, with bytes b0..b2 in read order. X is b1, or b1-256 when b0 bit 4 is set. Y is b2, or b2-256 when b0 bit 5 is set. Both are sign-extended to 16 bits. `out_btn_o` is b0 bit 0 when `tap_en_i` is 1 and 0 otherwise. Z is 0, `out_rel_o` is 1, and the clip and scale settings have no effect.
- R5: Absolute decode, with bytes b0..b3 in read order. X = {b2[3:0], b0} and Y = {b2[7:4], b1}. Z = b3[5:0], so bits 7:6 of b3 are ignored. `out_btn_o` is 0 and `out_rel_o` is 0.
- R6: After the last packet read of each fetch, exactly one write of 0x00 to address 0x02 is issued and acknowledged before `out_valid_o` rises.
- R7: In absolute mode with `clip_en_i`=1 and a non-idle sample, X is clamped to [`win_x_min_i`, `win_x_max_i`] and Y to [`win_y_min_i`, `win_y_max_i`].
- R8: An absolute sample with X, Y and Z all zero is output as all zeros, even when clipping and scaling are enabled.
- R9: In absolute mode with both `clip_en_i` and `scale_en_i` set and a non-idle sample, each axis is output as floor((c-min)*res/(max-min)), truncated to 16 bits, where c is the clamped value. `scale_en_i` alone has no effect.
- R10: Each fetch yields exactly one `out_valid_o` pulse, one cycle wide, and only after both axes are complete.
- R11: A `drdy_i` rising edge during a fetch is latched, and one more fetch follows the current one. Any number of edges during one fetch produce one further fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drdy_i | input | 1 | Data-ready level from the sensor, synchronous to clk_i |
| rel_mode_i | input | 1 | 1 = relative packet format, 0 = absolute |
| tap_en_i | input | 1 | Report the tap button in relative mode |
| clip_en_i | input | 1 | Clamp absolute coordinates to the window |
| scale_en_i | input | 1 | Rescale clamped coordinates (needs clip_en_i) |
| win_x_min_i | input | 16 | X window lower bound |
| win_x_max_i | input | 16 | X window upper bound |
| win_y_min_i | input | 16 | Y window lower bound |
| win_y_max_i | input | 16 | Y window upper bound |
| res_x_i | input | 16 | X target resolution |
| res_y_i | input | 16 | Y target resolution |
| req_valid_o | output | 1 | Register access request valid |
| req_ready_i | input | 1 | Request accepted |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 5 | Register address |
| req_wdata_o | output | 8 | Write data |
| rsp_valid_i | input | 1 | Response (read data or write acknowledge) valid |
| rsp_rdata_i | input | 8 | Read data |
| out_valid_o | output | 1 | Record strobe, one cycle |
| out_rel_o | output | 1 | Record is relative |
| out_x_o | output | 16 | X (signed delta or absolute) |
| out_y_o | output | 16 | Y (signed delta or absolute) |
| out_z_o | output | 6 | Pressure (absolute only) |
| out_btn_o | output | 1 | Tap button (relative only) |

## Verification
The assertions take several things about the inputs for granted. Each window lower bound must be strictly below its upper bound, so the divisor is never zero. The configuration inputs must stay stable from the data-ready edge until one cycle after the record strobe. The register master must return exactly one response per accepted request and none otherwise. The bench keeps fixed windows with min < max and changes the configuration only when the previous record has drained. Its responder model answers one cycle after each accepted request, while a repeating pattern drops `req_ready_i` to exercise request holding.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] ADDR_STATUS  = 8'h02;
  localparam logic [7:0] ADDR_REL_PKT = 8'h12;
  localparam logic [7:0] ADDR_ABS_PKT = 8'h14;
  localparam int unsigned REL_BYTES = 3;
  localparam int unsigned ABS_BYTES = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CLR_REQ,
    ST_CLR_WAIT,
    ST_PROC,
    ST_DIV,
    ST_DONE
  } tpd_state_e;
endpackage

// File: rtl/tpd_edge.sv
module tpd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic take_i,
  output logic pend_o
);
  logic lvl_q;
  logic rise;

  assign rise = lvl_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_o <= rise | (pend_o & ~take_i);
    end
  end

  AST_RISE_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && !lvl_q) |=> pend_o); // R11
endmodule

// File: rtl/tpd_decode.sv
module tpd_decode #(
  parameter int unsigned CW = 16
) (
  input  logic          rel_i,
  input  logic          tap_en_i,
  input  logic [7:0]    b0_i,
  input  logic [7:0]    b1_i,
  input  logic [7:0]    b2_i,
  input  logic [5:0]    b3_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic [5:0]    z_o,
  output logic          btn_o,
  output logic          idle_o
);
  // CW must exceed 12 so the absolute zero-extension is non-empty
  always_comb begin
    if (rel_i) begin
      x_o    = {{(CW-8){b0_i[4]}}, b1_i};
      y_o    = {{(CW-8){b0_i[5]}}, b2_i};
      z_o    = '0;
      btn_o  = tap_en_i & b0_i[0];
      idle_o = 1'b0;
    end else begin
      x_o    = {{(CW-12){1'b0}}, b2_i[3:0], b0_i};
      y_o    = {{(CW-12){1'b0}}, b2_i[7:4], b1_i};
      z_o    = b3_i;
      btn_o  = 1'b0;
      idle_o = ~|{b0_i, b1_i, b2_i, b3_i};
    end
  end
endmodule

// File: rtl/tpd_div.sv
module tpd_div #(
  parameter int unsigned NW = 32,
  parameter int unsigned DVW = 16,
  parameter int unsigned QW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [NW-1:0]  dividend_i,
  input  logic [DVW-1:0] divisor_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [QW-1:0]  quot_o
);
  localparam int unsigned CNT_W = $clog2(NW + 1);

  logic [NW-1:0]  dvd_q;
  logic [DVW-1:0] div_q;
  logic [DVW-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DVW:0]   trial;
  logic [DVW:0]   diff;
  logic           ge;

  assign trial = {rem_q, dvd_q[NW-1]};
  assign ge    = trial >= {1'b0, div_q};
  assign diff  = trial - {1'b0, div_q};
  assign quot_o = dvd_q[QW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      div_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        dvd_q  <= dividend_i;
        div_q  <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(NW);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= ge ? diff[DVW-1:0] : trial[DVW-1:0];
        dvd_q <= {dvd_q[NW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DIV_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R10
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> divisor_i != '0); // R9
endmodule

// File: rtl/tpd_axis.sv
module tpd_axis #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] v_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] res_i,
  output logic [CW-1:0] clip_o,
  output logic [CW-1:0] quot_o,
  output logic          done_o
);
  localparam int unsigned PW = 2 * CW;

  logic [CW-1:0] lo_clamped;
  logic [CW-1:0] offs;
  logic [PW-1:0] prod;
  logic          busy;

  assign lo_clamped = (v_i < lo_i) ? lo_i : v_i;
  assign clip_o     = (lo_clamped > hi_i) ? hi_i : lo_clamped;
  assign offs       = clip_o - lo_i;
  assign prod       = {{CW{1'b0}}, offs} * {{CW{1'b0}}, res_i};

  tpd_div #(.NW(PW), .DVW(CW), .QW(CW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dividend_i (prod),
    .divisor_i  (hi_i - lo_i),
    .busy_o     (busy),
    .done_o     (done_o),
    .quot_o     (quot_o)
  );

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy && $past(busy)); // R10
endmodule

// File: rtl/touch_packet_decoder.sv
module touch_packet_decoder #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drdy_i,
  input  logic          rel_mode_i,
  input  logic          tap_en_i,
  input  logic          clip_en_i,
  input  logic          scale_en_i,
  input  logic [CW-1:0] win_x_min_i,
  input  logic [CW-1:0] win_x_max_i,
  input  logic [CW-1:0] win_y_min_i,
  input  logic [CW-1:0] win_y_max_i,
  input  logic [CW-1:0] res_x_i,
  input  logic [CW-1:0] res_y_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [7:0]    req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [7:0]    rsp_rdata_i,
  output logic          out_valid_o,
  output logic          out_rel_o,
  output logic [CW-1:0] out_x_o,
  output logic [CW-1:0] out_y_o,
  output logic [5:0]    out_z_o,
  output logic          out_btn_o
);
  import tpd_pkg::*;

  localparam int unsigned NAX = 2;

  tpd_state_e state_q;
  logic [1:0] idx_q, last_idx;
  logic       mode_q;
  logic [7:0] b0_q, b1_q, b2_q;
  logic [5:0] b3_q;
  logic       pend, take;
  logic [AW-1:0] base_addr;

  logic [CW-1:0] dec_x, dec_y;
  logic [5:0]    dec_z;
  logic          dec_btn, dec_idle;
  logic          do_clip, do_scale, div_start;

  logic [NAX-1:0][CW-1:0] ax_raw, ax_lo, ax_hi, ax_res, ax_clip, ax_quot;
  logic [NAX-1:0]         ax_done;

  logic idle_q, act_clip_q, act_scale_q;

  assign take      = (state_q == ST_IDLE) && pend;
  assign last_idx  = mode_q ? 2'(REL_BYTES - 1) : 2'(ABS_BYTES - 1);
  assign base_addr = mode_q ? AW'(ADDR_REL_PKT) : AW'(ADDR_ABS_PKT);

  assign req_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_CLR_REQ);
  assign req_write_o = (state_q == ST_CLR_REQ);
  assign req_addr_o  = req_write_o ? AW'(ADDR_STATUS) : base_addr + AW'(idx_q);
  assign req_wdata_o = 8'h00;
  assign out_valid_o = (state_q == ST_DONE);

  tpd_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (drdy_i),
    .take_i (take),
    .pend_o (pend)
  );

  tpd_decode #(.CW(CW)) u_decode (
    .rel_i    (mode_q),
    .tap_en_i (tap_en_i),
    .b0_i     (b0_q),
    .b1_i     (b1_q),
    .b2_i     (b2_q),
    .b3_i     (b3_q),
    .x_o      (dec_x),
    .y_o      (dec_y),
    .z_o      (dec_z),
    .btn_o    (dec_btn),
    .idle_o   (dec_idle)
  );

  assign do_clip   = ~mode_q & clip_en_i & ~dec_idle;
  assign do_scale  = do_clip & scale_en_i;
  assign div_start = (state_q == ST_PROC) && do_scale;

  assign ax_raw = {dec_y, dec_x};
  assign ax_lo  = {win_y_min_i, win_x_min_i};
  assign ax_hi  = {win_y_max_i, win_x_max_i};
  assign ax_res = {res_y_i, res_x_i};

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    tpd_axis #(.CW(CW)) u_axis (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (div_start),
      .v_i     (ax_raw[g]),
      .lo_i    (ax_lo[g]),
      .hi_i    (ax_hi[g]),
      .res_i   (ax_res[g]),
      .clip_o  (ax_clip[g]),
      .quot_o  (ax_quot[g]),
      .done_o  (ax_done[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      mode_q      <= 1'b0;
      b0_q        <= '0;
      b1_q        <= '0;
      b2_q        <= '0;
      b3_q        <= '0;
      out_rel_o   <= 1'b0;
      out_x_o     <= '0;
      out_y_o     <= '0;
      out_z_o     <= '0;
      out_btn_o   <= 1'b0;
      idle_q      <= 1'b0;
      act_clip_q  <= 1'b0;
      act_scale_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pend) begin
          state_q <= ST_RD_REQ;
          idx_q   <= '0;
          mode_q  <= rel_mode_i;
        end
        ST_RD_REQ: if (req_ready_i) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid_i) begin
          unique case (idx_q)
            2'd0: b0_q <= rsp_rdata_i;
            2'd1: b1_q <= rsp_rdata_i;
            2'd2: b2_q <= rsp_rdata_i;
            default: b3_q <= rsp_rdata_i[5:0];
          endcase
          if (idx_q == last_idx) begin
            state_q <= ST_CLR_REQ;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_RD_REQ;
          end
        end
        ST_CLR_REQ: if (req_ready_i) state_q <= ST_CLR_WAIT;
        ST_CLR_WAIT: if (rsp_valid_i) state_q <= ST_PROC;
        ST_PROC: begin
          out_rel_o   <= mode_q;
          out_z_o     <= dec_z;
          out_btn_o   <= dec_btn;
          idle_q      <= dec_idle;
          act_clip_q  <= do_clip;
          act_scale_q <= do_scale;
          out_x_o     <= do_clip ? ax_clip[0] : dec_x;
          out_y_o     <= do_clip ? ax_clip[1] : dec_y;
          state_q     <= do_scale ? ST_DIV : ST_DONE;
        end
        ST_DIV: if (&ax_done) begin
          out_x_o <= ax_quot[0];
          out_y_o <= ax_quot[1];
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // handshake counters for checking only
  logic [2:0] chk_rd_q, chk_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_rd_q <= '0;
      chk_wr_q <= '0;
    end else if (take) begin
      chk_rd_q <= '0;
      chk_wr_q <= '0;
    end else if (req_valid_o && req_ready_i) begin
      if (req_write_o) chk_wr_q <= chk_wr_q + 1'b1;
      else             chk_rd_q <= chk_rd_q + 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_write_o)); // R3
  AST_RD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> chk_rd_q == (out_rel_o ? 3'd3 : 3'd4)); // R3
  AST_CLR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> chk_wr_q == 3'd1); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R10
  AST_REL_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_rel_o |-> out_z_o == '0); // R4
  AST_CLIP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && act_clip_q && !act_scale_q |->
      out_x_o >= win_x_min_i && out_x_o <= win_x_max_i &&
      out_y_o >= win_y_min_i && out_y_o <= win_y_max_i); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && idle_q |-> out_x_o == '0 && out_y_o == '0 && out_z_o == '0); // R8
endmodule

// File: tb/touch_packet_decoder_tb.sv
`timescale 1ns/1ps
module touch_packet_decoder_tb_top;
  localparam int CW = 16;
  localparam int AW = 5;
  localparam logic [15:0] XLO = 16'd300, XHI = 16'd3800, YLO = 16'd100, YHI = 16'd4000;
  localparam logic [15:0] XRES = 16'd1024, YRES = 16'd768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy = 1'b0;
  logic rel_mode = 1'b0, tap_en = 1'b0, clip_en = 1'b0, scale_en = 1'b0;
  logic [CW-1:0] wxl = XLO, wxh = XHI, wyl = YLO, wyh = YHI, rx = XRES, ry = YRES;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [7:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;
  logic out_valid, out_rel, out_btn;
  logic [CW-1:0] out_x, out_y;
  logic [5:0] out_z;

  always #5 clk = ~clk;

  touch_packet_decoder #(.CW(CW), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .drdy_i(drdy),
    .rel_mode_i(rel_mode), .tap_en_i(tap_en), .clip_en_i(clip_en), .scale_en_i(scale_en),
    .win_x_min_i(wxl), .win_x_max_i(wxh), .win_y_min_i(wyl), .win_y_max_i(wyh),
    .res_x_i(rx), .res_y_i(ry),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
    .out_valid_o(out_valid), .out_rel_o(out_rel), .out_x_o(out_x), .out_y_o(out_y),
    .out_z_o(out_z), .out_btn_o(out_btn)
  );

  // register responder model
  logic [7:0] regs [0:31];
  logic [4:0] rd_log [0:1023];
  int rd_n = 0, wr_n = 0, wr_ok = 0, vcnt = 0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      if (req_write) begin
        rsp_rdata <= 8'h00;
        wr_n <= wr_n + 1;
        if (req_addr == 5'h02 && req_wdata == 8'h00) wr_ok <= wr_ok + 1;
      end else begin
        rsp_rdata <= regs[req_addr];
        rd_log[rd_n[9:0]] <= req_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  always @(negedge clk) if (out_valid) vcnt = vcnt + 1;

  initial begin
    int k;
    k = 0;
    req_ready = 1'b0;
    forever begin
      @(negedge clk);
      k++;
      req_ready = (k % 3) != 2;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic pulse_drdy();
    @(negedge clk); drdy = 1'b1;
    repeat (2) @(negedge clk);
    drdy = 1'b0;
  endtask

  function automatic logic [15:0] abs_exp(input logic [15:0] v, lo, hi, res,
                                          input bit clip, scale, idle);
    logic [15:0] c;
    logic [31:0] p;
    if (!clip || idle) return v;
    c = (v < lo) ? lo : ((v > hi) ? hi : v);
    if (!scale) return c;
    p = ({16'd0, c - lo} * {16'd0, res}) / {16'd0, hi - lo};
    return p[15:0];
  endfunction

  task automatic run_rec(input logic rel, input logic [15:0] ex, ey, input logic [5:0] ez,
                         input logic eb, input string rq);
    int rb, wb, wo, vb, t;
    logic [4:0] base;
    int nb;
    rb = rd_n; wb = wr_n; wo = wr_ok; vb = vcnt;
    base = rel ? 5'h12 : 5'h14;
    nb = rel ? 3 : 4;
    pulse_drdy();
    t = 0;
    while (!out_valid && t < 2000) begin @(negedge clk); t++; end
    chk("R10 strobe seen", 32'(t < 2000), 32'd1);
    chk({rq, " x"}, 32'(out_x), 32'(ex));
    chk({rq, " y"}, 32'(out_y), 32'(ey));
    chk({rq, " z"}, 32'(out_z), 32'(ez));
    chk({rq, " btn"}, 32'(out_btn), 32'(eb));
    chk({rq, " rel flag"}, 32'(out_rel), 32'(rel));
    chk("R3 read count", 32'(rd_n - rb), 32'(nb));
    for (int i = 0; i < nb; i++) chk("R3 read address", 32'(rd_log[(rb + i) % 1024]), 32'(base + 5'(i)));
    chk("R6 status write count", 32'(wr_n - wb), 32'd1);
    chk("R6 status write value", 32'(wr_ok - wo), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R10 one pulse", 32'(vcnt - vb), 32'd1);
  endtask

  task automatic load_abs(input logic [11:0] x, y, input logic [5:0] z);
    regs[5'h14] = x[7:0];
    regs[5'h15] = y[7:0];
    regs[5'h16] = {y[11:8], x[11:8]};
    regs[5'h17] = {2'b11, z};
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 no request idle", 32'(req_valid), 32'd0);
    chk("R1 no read idle", 32'(rd_n), 32'd0);
    chk("R1 no strobe idle", 32'(vcnt), 32'd0);

    // absolute sweep across clip/scale configurations (R5, R7, R9)
    rel_mode = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      clip_en = cfg[0]; scale_en = cfg[1];
      for (int i = 0; i < 16; i++) begin
        logic [11:0] x, y;
        logic [5:0] z;
        x = 12'(i * 273);
        y = 12'(4095 - i * 260);
        z = 6'(i * 4 + 1);
        load_abs(x, y, z);
        run_rec(1'b0, abs_exp({4'd0, x}, XLO, XHI, XRES, clip_en, scale_en, 1'b0),
                abs_exp({4'd0, y}, YLO, YHI, YRES, clip_en, scale_en, 1'b0), z, 1'b0,
                cfg == 0 ? "R5" : (cfg == 1 ? "R7" : (cfg == 2 ? "R9 scale alone" : "R9")));
        @(negedge clk);
      end
    end

    // idle sample with clip and scale on, z upper bits set (R8)
    clip_en = 1'b1; scale_en = 1'b1;
    load_abs(12'd0, 12'd0, 6'd0);
    run_rec(1'b0, 16'd0, 16'd0, 6'd0, 1'b0, "R8");
    // non-idle only by z: clipped to window minimum
    scale_en = 1'b0;
    load_abs(12'd0, 12'd0, 6'd1);
    run_rec(1'b0, XLO, YLO, 6'd1, 1'b0, "R8 z nonzero");
    clip_en = 1'b0;

    // relative sweep over sign bits, button and tap enable (R4)
    rel_mode = 1'b1;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b0, b1, b2;
      b0 = {2'b00, i[2], i[1], 3'b000, i[0]};
      b1 = 8'(i * 8 + 3);
      b2 = 8'(255 - i * 7);
      tap_en = i[3];
      clip_en = i[4]; scale_en = i[4];
      regs[5'h12] = b0; regs[5'h13] = b1; regs[5'h14] = b2;
      run_rec(1'b1, {{8{b0[4]}}, b1}, {{8{b0[5]}}, b2}, 6'd0, i[3] & b0[0], "R4");
      @(negedge clk);
    end

    // edges during a fetch coalesce into one more (R11)
    begin
      int rb, vb;
      rel_mode = 1'b0; clip_en = 1'b1; scale_en = 1'b1;
      load_abs(12'd2000, 12'd1500, 6'd9);
      rb = rd_n; vb = vcnt;
      pulse_drdy();
      repeat (4) @(negedge clk);
      pulse_drdy();
      @(negedge clk);
      pulse_drdy();
      repeat (400) @(negedge clk);
      chk("R11 records after busy edges", 32'(vcnt - vb), 32'd2);
      chk("R11 reads after busy edges", 32'(rd_n - rb), 32'd8);
      chk("R11 x", 32'(out_x), 32'(abs_exp(16'd2000, XLO, XHI, XRES, 1, 1, 0)));
    end

    // level held high starts one fetch (R2)
    begin
      int vb;
      clip_en = 1'b0; scale_en = 1'b0;
      vb = vcnt;
      @(negedge clk); drdy = 1'b1;
      repeat (300) @(negedge clk);
      drdy = 1'b0;
      repeat (100) @(negedge clk);
      chk("R2 held level one record", 32'(vcnt - vb), 32'd1);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule